// File: doc/BRIEF.md
# Parsimony Subtree Score Accumulator

This stage produces the mutation score of a subtree while a tree is scored bottom-up. A command names two child score slots and, for an inner-node step, a parent slot. When the command is accepted, the two child scores are read from a 2048-entry score store and added. A stream of partial mutation counts then follows, one per vector memory line. The stream is summed and the total is added to the child-score sum.

For an inner-node step, the resulting score is written back into the store at the parent slot, so that later steps can use it as a child score. For a root step, nothing is stored and the score is presented on a result port for one cycle. Slots never written since reset read as zero. This is what leaf nodes need, because they carry no mutations of their own.

Each count line is flagged with a first-line marker and a last-line marker. A new command may be accepted in the same cycle as the previous operation's last count line. This keeps the stream free of bubbles between operations.

Top module: `pscore_stage`

## Requirements
- R1: After reset, `res_valid` and `res_score` are 0, and every score slot reads as zero until it is written.
- R2: On a cycle with `cmd_valid` high, the scores at `cmd_q_addr` and `cmd_r_addr` are read and their 32-bit sum is held until the operation's final combine.
- R3: A count line (`cnt_valid` high) with `cnt_first` high restarts the running total at `cnt_value`. Other count lines add `cnt_value` to it. Cycles with `cnt_valid` low leave the total unchanged.
- R4: For a root step (`cmd_root` = 1), `res_valid` is high for exactly the cycle after the last-line marker. In that cycle `res_score` equals the child-score sum plus the running total, including the last line, taken modulo 2^32.
- R5: For an inner-node step (`cmd_root` = 0), the final score is written to the slot at `cmd_p_addr` on the last-line edge, and `res_valid` stays low.
- R6: A command accepted in the same cycle as the previous operation's last count line works correctly. If it reads the slot being written in that cycle, it receives the newly written score.
- R7: Only the low 11 bits of each 16-bit address select a slot. Addresses that differ only in bits 15..11 refer to the same slot.
- R8: An operation with a single count line, marked both first and last, scores the child sum plus that one count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Accept a command this cycle |
| cmd_root | input | 1 | 1 = root step (score returned), 0 = inner-node step (score stored) |
| cmd_q_addr | input | 16 | First child score slot |
| cmd_r_addr | input | 16 | Second child score slot |
| cmd_p_addr | input | 16 | Parent score slot (inner-node step) |
| cnt_valid | input | 1 | A partial count line is present |
| cnt_first | input | 1 | This line is the first of the operation |
| cnt_last | input | 1 | This line is the last of the operation |
| cnt_value | input | 16 | Partial mutation count of the line |
| res_valid | output | 1 | Root score valid (one cycle) |
| res_score | output | 32 | Root score |

## Verification
In one cycle, the store can receive an inner-node step's write-back while the next command reads its child scores. This happens when the second command arrives together with the first operation's last count line and reads the parent slot just written. The bench provokes this by overlapping an inner-node step with a root step whose children are both that parent slot. It then compares the root result with twice the fresh parent score plus the root's own count. A stale read would instead give a value built on zero.

// File: rtl/pscore_pkg.sv
package pscore_pkg;
  localparam int SCORE_W = 32;
  typedef logic [SCORE_W-1:0] score_t;

  // adder 1: sum of the two child scores
  function automatic score_t child_pair_sum(score_t a, score_t b);
    return a + b;
  endfunction

  // adder 2: one step of the streaming count accumulator
  function automatic score_t stream_step(score_t total, score_t line, logic restart);
    return restart ? line : total + line;
  endfunction

  // adder 3: final combine of child sum and streamed total
  function automatic score_t final_combine(score_t kids, score_t streamed);
    return kids + streamed;
  endfunction
endpackage

// File: rtl/pscore_store.sv
module pscore_store
  import pscore_pkg::*;
#(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_a_addr,
  input  logic [AW-1:0] rd_b_addr,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  score_t        wr_data,
  output score_t        rd_a_data,
  output score_t        rd_b_data
);
  score_t           slots [DEPTH];
  logic [DEPTH-1:0] written;
  logic [AW-1:0]    rd_addr [2];
  score_t           peek    [2];
  score_t           rd_q    [2];
  logic             fwd_hit [2];

  assign rd_addr[0] = rd_a_addr;
  assign rd_addr[1] = rd_b_addr;

  for (genvar g = 0; g < 2; g++) begin : g_port
    // same-cycle write to the read slot is forwarded (R6)
    assign fwd_hit[g] = wr_en && (wr_addr == rd_addr[g]);
    // never-written slots read as zero (R1)
    assign peek[g] = fwd_hit[g]            ? wr_data :
                     written[rd_addr[g]]   ? slots[rd_addr[g]] : '0;
  end

  always_ff @(posedge clk) begin
    if (wr_en) slots[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) written <= '0;
    else if (wr_en) written[wr_addr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) rd_q[i] <= '0;
    end else if (rd_en) begin
      for (int i = 0; i < 2; i++) rd_q[i] <= peek[i];
    end
  end

  assign rd_a_data = rd_q[0];
  assign rd_b_data = rd_q[1];

  assert_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && wr_en && (wr_addr == rd_a_addr)) |=> (rd_a_data == $past(wr_data)));

  assert_unwritten_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !(wr_en && (wr_addr == rd_b_addr)) && !written[rd_b_addr]) |=> (rd_b_data == '0));
endmodule

// File: rtl/pscore_stream.sv
module pscore_stream
  import pscore_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_first,
  input  logic [CNT_W-1:0] in_value,
  output score_t           total_next,
  output score_t           total_q
);
  score_t line_ext;
  assign line_ext   = score_t'(in_value);
  assign total_next = in_valid ? stream_step(total_q, line_ext, in_first) : total_q;

  always_ff @(posedge clk) begin
    if (!rst_n) total_q <= '0;
    else        total_q <= total_next;
  end

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(total_q));

  assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_first) |=> (total_q == score_t'($past(in_value))));
endmodule

// File: rtl/pscore_stage.sv
module pscore_stage
  import pscore_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int CMD_AW = 16,
  parameter int CNT_W = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_root,
  input  logic [CMD_AW-1:0] cmd_q_addr,
  input  logic [CMD_AW-1:0] cmd_r_addr,
  input  logic [CMD_AW-1:0] cmd_p_addr,
  input  logic              cnt_valid,
  input  logic              cnt_first,
  input  logic              cnt_last,
  input  logic [CNT_W-1:0]  cnt_value,
  output logic              res_valid,
  output score_t            res_score
);
  logic          op_root;
  logic [AW-1:0] op_p;
  score_t        kid_a, kid_b, kid_sum;
  score_t        stream_next, stream_q;
  score_t        final_score;
  logic          finish;
  logic          store_we;
  logic          unused_hi_bits;

  // high address bits select nothing (R7)
  assign unused_hi_bits = ^{cmd_q_addr[CMD_AW-1:AW], cmd_r_addr[CMD_AW-1:AW],
                            cmd_p_addr[CMD_AW-1:AW], stream_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_root <= 1'b0;
      op_p    <= '0;
    end else if (cmd_valid) begin
      op_root <= cmd_root;
      op_p    <= cmd_p_addr[AW-1:0];
    end
  end

  pscore_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (cmd_valid),
    .rd_a_addr (cmd_q_addr[AW-1:0]),
    .rd_b_addr (cmd_r_addr[AW-1:0]),
    .wr_en     (store_we),
    .wr_addr   (op_p),
    .wr_data   (final_score),
    .rd_a_data (kid_a),
    .rd_b_data (kid_b)
  );

  pscore_stream #(.CNT_W(CNT_W)) u_stream (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (cnt_valid),
    .in_first   (cnt_first),
    .in_value   (cnt_value),
    .total_next (stream_next),
    .total_q    (stream_q)
  );

  assign kid_sum     = child_pair_sum(kid_a, kid_b);
  assign final_score = final_combine(kid_sum, stream_next);
  assign finish      = cnt_valid && cnt_last;
  assign store_we    = finish && !op_root;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_score <= '0;
    end else begin
      res_valid <= finish && op_root;
      if (finish && op_root) res_score <= final_score;
    end
  end

  assert_result_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(cnt_valid && cnt_last));

  assert_result_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> (res_valid || $stable(res_score)));
endmodule

// File: tb/pscore_stage_test.sv
module pscore_stage_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;

  typedef struct packed {
    logic        root;
    logic [15:0] q;
    logic [15:0] r;
    logic [15:0] p;
    logic [7:0]  n;
    logic [15:0] base;
    logic        gap;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 16'd100, 16'd101, 16'd10, 8'd3, 16'd2,   1'b0},
    '{1'b0, 16'd102, 16'd103, 16'd11, 8'd4, 16'd1,   1'b1},
    '{1'b1, 16'd10,  16'd11,  16'd0,  8'd2, 16'd5,   1'b0},
    '{1'b0, 16'd10,  16'd104, 16'd12, 8'd1, 16'd7,   1'b0},
    '{1'b1, 16'd12,  16'd11,  16'd0,  8'd3, 16'd0,   1'b0},
    '{1'b1, 16'd104, 16'd105, 16'd0,  8'd5, 16'd100, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid, cmd_root;
  logic [15:0] cmd_q_addr, cmd_r_addr, cmd_p_addr;
  logic        cnt_valid, cnt_first, cnt_last;
  logic [15:0] cnt_value;
  logic        res_valid;
  logic [31:0] res_score;

  int checks = 0;
  int failures = 0;
  logic [31:0] model [2048];

  always #(CLK_PERIOD/2) clk = ~clk;

  pscore_stage uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_root(cmd_root),
    .cmd_q_addr(cmd_q_addr), .cmd_r_addr(cmd_r_addr), .cmd_p_addr(cmd_p_addr),
    .cnt_valid(cnt_valid), .cnt_first(cnt_first), .cnt_last(cnt_last),
    .cnt_value(cnt_value), .res_valid(res_valid), .res_score(res_score)
  );

  task automatic check_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < 2048; i++) model[i] = 32'd0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_root = 1'b0;
    cmd_q_addr = '0; cmd_r_addr = '0; cmd_p_addr = '0;
    cnt_valid = 1'b0; cnt_first = 1'b0; cnt_last = 1'b0; cnt_value = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clear_model();
  endtask

  // issue one command, then its count lines starting the next cycle
  task automatic run_op(input string req, input vec_t v);
    logic [31:0] sum;
    logic [31:0] exp;
    sum = 32'd0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_root = v.root;
    cmd_q_addr = v.q; cmd_r_addr = v.r; cmd_p_addr = v.p;
    exp = model[v.q[AW-1:0]] + model[v.r[AW-1:0]];
    for (int i = 0; i < int'(v.n); i++) begin
      @(negedge clk);
      cmd_valid = 1'b0;
      if (v.gap && i > 0) begin
        cnt_valid = 1'b0;
        @(negedge clk);
      end
      cnt_valid = 1'b1;
      cnt_first = (i == 0);
      cnt_last  = (i == int'(v.n) - 1);
      cnt_value = v.base + 16'(i);
      sum = sum + 32'(v.base) + 32'(i);
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    cnt_valid = 1'b0; cnt_first = 1'b0; cnt_last = 1'b0;
    exp = exp + sum;
    if (v.root) begin
      check_eq({req, " R4 res_valid"}, 32'(res_valid), 32'd1);
      check_eq({req, " R4 res_score"}, res_score, exp);
    end else begin
      check_eq({req, " R5 res_valid low on inner step"}, 32'(res_valid), 32'd0);
      model[v.p[AW-1:0]] = exp;
    end
    @(negedge clk);
    check_eq({req, " R4 single-cycle pulse"}, 32'(res_valid), 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL R4 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    check_eq("R1 reset res_valid", 32'(res_valid), 32'd0);
    check_eq("R1 reset res_score", res_score, 32'd0);

    // table walk: R2 child sum, R3 restart/hold, R8 single line (entry 3)
    for (int k = 0; k < 6; k++) run_op($sformatf("vec%0d R2 R3", k), VECS[k]);

    // R7: high address bits alias onto the same slot
    run_op("R7 store", '{1'b0, 16'd200, 16'd201, 16'h0820, 8'd1, 16'd4, 1'b0});
    run_op("R7 read",  '{1'b1, 16'hF820, 16'd300, 16'd0, 8'd1, 16'd1, 1'b0});
    check_eq("R7 aliased slot score", res_score, 32'd5);

    // R6: next command overlaps last line, reads the slot just written
    @(negedge clk);
    cmd_valid = 1'b1; cmd_root = 1'b0;
    cmd_q_addr = 16'd400; cmd_r_addr = 16'd401; cmd_p_addr = 16'd50;
    @(negedge clk);
    cmd_valid = 1'b0;
    cnt_valid = 1'b1; cnt_first = 1'b1; cnt_last = 1'b0; cnt_value = 16'd3;
    @(negedge clk);
    cnt_first = 1'b0; cnt_last = 1'b1; cnt_value = 16'd4;
    cmd_valid = 1'b1; cmd_root = 1'b1;
    cmd_q_addr = 16'd50; cmd_r_addr = 16'd50; cmd_p_addr = 16'd0;
    @(negedge clk);
    cmd_valid = 1'b0;
    check_eq("R6 R5 inner step gives no result", 32'(res_valid), 32'd0);
    cnt_first = 1'b1; cnt_last = 1'b1; cnt_value = 16'd1;
    @(negedge clk);
    cnt_valid = 1'b0; cnt_first = 1'b0; cnt_last = 1'b0;
    check_eq("R6 overlapped root valid", 32'(res_valid), 32'd1);
    check_eq("R6 forwarded parent score", res_score, 32'd15);

    // R1: reset forgets written slots
    do_reset();
    run_op("R1 after reset", '{1'b1, 16'd10, 16'd11, 16'd0, 8'd1, 16'd2, 1'b0});
    check_eq("R1 cleared slots read zero", res_score, 32'd2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule